// File: doc/BRIEF.md
# Dual-Sample Coarse Count Corrector

This block is the coarse stage of a hybrid time-to-digital converter. A free-running counter advances on every system clock. A hit arrives on two inputs: the original pulse, and a copy that outside logic has delayed by a fixed fraction of a clock period. Both inputs are asynchronous to the clock. When a line changes close to a clock edge, the count it latches can be one cycle early or late. Each line is synchronized, its rising edge is detected, and the counter value is captured for that line. The two captures of one event are then paired and subtracted.

With a delay shorter than one period, the delayed capture of a correct pair is equal to the original capture or one higher. A difference outside that range exposes a capture that slipped by a cycle, and the block corrects the original count by one. Any other difference, or a pair whose partner never arrives, is reported with an error flag. The corrected count is later joined with a fine interpolator result. The delay line and the interpolator are not part of this block.

Top module: `coarse_pair_corrector`

## Requirements
- R1: `count_o` is 0 during synchronous reset and increases by exactly one on every clock edge with reset low. It wraps from all ones to 0 (16 bits by default).
- R2: Synchronous reset clears `valid_o`, `err_o` and `overrun_o` to 0. It also clears the counter and any half-formed pair.
- R3: The raw capture of a line equals the `count_o` value in the clock cycle in which that input rises, plus the number of synchronizer stages (2 by default).
- R4: If the delayed raw capture minus the original raw capture is 0 or 1, `coarse_o` equals the original capture.
- R5: If that difference is 2, `coarse_o` equals the original capture plus one.
- R6: If that difference is -1 (all ones modulo the counter width), `coarse_o` equals the original capture minus one.
- R7: For any other difference, `err_o` is 1 with the result, and `coarse_o` equals the original capture.
- R8: Each completed pair, or each expired pair, produces exactly one `valid_o` pulse that lasts one cycle. `err_o` is 1 only while `valid_o` is 1, and `coarse_o` changes only on cycles in which `valid_o` is 1.
- R9: After the first edge of a pair, the partner edge is accepted in either of the next 2 cycles. If no partner edge arrives, the block reports the lone capture on `coarse_o` with `err_o` set.
- R10: A further rising edge on a line whose capture is already held, before the pair completes, is ignored. It does not change the pending result, and it sets `overrun_o`, which stays 1 until reset.
- R11: The difference is taken modulo the counter width, so a pair whose captures span the counter wrap is classified and corrected like any other pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the counter clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_orig_i | input | 1 | Original hit pulse, asynchronous |
| hit_dly_i | input | 1 | Delayed copy of the hit pulse, asynchronous |
| count_o | output | CNT_W | Free-running coarse counter |
| coarse_o | output | CNT_W | Corrected coarse count of the latest pair |
| valid_o | output | 1 | One-cycle strobe qualifying `coarse_o` and `err_o` |
| err_o | output | 1 | Pair could not be corrected (bad difference or missing partner) |
| overrun_o | output | 1 | Sticky: a hit arrived while a pair was still open |

## Verification
The pairing state is the weak point. If it is stuck open, a later pair produces no strobe. If it is stuck idle, each edge produces its own error strobe. Either fault shows at `valid_o` within a few cycles of the next hit. A wrong held capture or a wrong correction offset shows as a `coarse_o` that is off by one or two from the value predicted from `count_o` at the moment the inputs rise, on the very strobe of that pair. A lost overrun flag shows on the next strobe after an extra edge, and a bad wrap subtraction shows only on pairs that straddle the counter rollover, so one such pair is driven deliberately.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   // Which line, if any, has a capture waiting for its partner
   typedef enum logic [1:0] {
      PAIR_IDLE   = 2'd0,
      PAIR_HAVE_A = 2'd1,
      PAIR_HAVE_B = 2'd2
   } pair_st_e;

endpackage

// File: rtl/ccc_sync_edge.sv
module ccc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_i,
   output logic rise_o
);
   timeunit 1ns;
   timeprecision 100ps;

   logic last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic q;
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= g_stage[i-1].q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= g_stage[STAGES-1].q;
   end

   assign rise_o = g_stage[STAGES-1].q & ~last_q;

endmodule

// File: rtl/ccc_free_counter.sv
module ccc_free_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt_o
);
   timeunit 1ns;
   timeprecision 100ps;

   always_ff @(posedge clk) begin
      if (rst) cnt_o <= '0;
      else     cnt_o <= cnt_o + CNT_W'(1);
   end

endmodule

// File: rtl/ccc_diff_fix.sv
module ccc_diff_fix #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] orig_i,
   input  logic [CNT_W-1:0] dly_i,
   output logic [CNT_W-1:0] fixed_o,
   output logic             bad_o
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [CNT_W-1:0] DIFF_TWO  = CNT_W'(2);
   localparam logic [CNT_W-1:0] DIFF_NEG1 = {CNT_W{1'b1}};

   logic [CNT_W-1:0] diff;
   assign diff = dly_i - orig_i;

   always_comb begin
      fixed_o = orig_i;
      bad_o   = 1'b0;
      if (diff == DIFF_TWO) begin
         fixed_o = orig_i + CNT_W'(1);
      end else if (diff == DIFF_NEG1) begin
         fixed_o = orig_i - CNT_W'(1);
      end else if (diff > CNT_W'(1)) begin
         bad_o = 1'b1;
      end
   end

endmodule

// File: rtl/ccc_pair_ctrl.sv
module ccc_pair_ctrl
   import ccc_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int PAIR_WIN = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rise_a_i,
   input  logic             rise_b_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] coarse_o,
   output logic             valid_o,
   output logic             err_o,
   output logic             overrun_o
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int WIN_W = $clog2(PAIR_WIN + 1);

   pair_st_e         st_q, st_d;
   logic [CNT_W-1:0] held_q, held_d;
   logic [WIN_W-1:0] win_q, win_d;
   logic             done, expired, extra_hit;
   logic [CNT_W-1:0] orig_v, dly_v, fixed_v;
   logic             bad_v;

   ccc_diff_fix #(.CNT_W(CNT_W)) i_fix (
      .orig_i (orig_v),
      .dly_i  (dly_v),
      .fixed_o(fixed_v),
      .bad_o  (bad_v)
   );

   always_comb begin
      st_d      = st_q;
      held_d    = held_q;
      win_d     = win_q;
      done      = 1'b0;
      expired   = 1'b0;
      extra_hit = 1'b0;
      orig_v    = cnt_i;
      dly_v     = cnt_i;
      unique case (st_q)
         PAIR_IDLE: begin
            if (rise_a_i && rise_b_i) begin
               done = 1'b1;
            end else if (rise_a_i) begin
               st_d   = PAIR_HAVE_A;
               held_d = cnt_i;
               win_d  = WIN_W'(1);
            end else if (rise_b_i) begin
               st_d   = PAIR_HAVE_B;
               held_d = cnt_i;
               win_d  = WIN_W'(1);
            end
         end
         PAIR_HAVE_A: begin
            orig_v    = held_q;
            extra_hit = rise_a_i;
            if (rise_b_i) begin
               done = 1'b1;
               st_d = PAIR_IDLE;
            end else if (win_q == WIN_W'(PAIR_WIN)) begin
               done    = 1'b1;
               expired = 1'b1;
               st_d    = PAIR_IDLE;
            end else begin
               win_d = WIN_W'(win_q + 1'b1);
            end
         end
         PAIR_HAVE_B: begin
            dly_v     = held_q;
            extra_hit = rise_b_i;
            if (rise_a_i) begin
               done = 1'b1;
               st_d = PAIR_IDLE;
            end else if (win_q == WIN_W'(PAIR_WIN)) begin
               done    = 1'b1;
               expired = 1'b1;
               st_d    = PAIR_IDLE;
            end else begin
               win_d = WIN_W'(win_q + 1'b1);
            end
         end
         default: st_d = PAIR_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q      <= PAIR_IDLE;
         held_q    <= '0;
         win_q     <= '0;
         coarse_o  <= '0;
         valid_o   <= 1'b0;
         err_o     <= 1'b0;
         overrun_o <= 1'b0;
      end else begin
         st_q      <= st_d;
         held_q    <= held_d;
         win_q     <= win_d;
         valid_o   <= done;
         err_o     <= done & (expired | bad_v);
         overrun_o <= overrun_o | extra_hit;
         if (done) coarse_o <= expired ? held_q : fixed_v;
      end
   end

endmodule

// File: rtl/coarse_pair_corrector.sv
module coarse_pair_corrector #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int PAIR_WIN    = 2,
   parameter int DLY_PCT     = 50
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hit_orig_i,
   input  logic             hit_dly_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] coarse_o,
   output logic             valid_o,
   output logic             err_o,
   output logic             overrun_o
);
   timeunit 1ns;
   timeprecision 100ps;

   if (CNT_W < 4) begin : g_bad_width
      $error("CNT_W must be at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PAIR_WIN < 2 || PAIR_WIN >= (1 << (CNT_W - 2))) begin : g_bad_win
      $error("PAIR_WIN must cover a difference of 2 and stay far below the wrap");
   end
   if (DLY_PCT < 1 || DLY_PCT > 99) begin : g_bad_dly
      $error("DLY_PCT must lie strictly inside one clock period");
   end

   logic rise_a, rise_b;

   ccc_free_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk  (clk),
      .rst  (rst),
      .cnt_o(count_o)
   );

   ccc_sync_edge #(.STAGES(SYNC_STAGES)) i_sync_a (
      .clk    (clk),
      .rst    (rst),
      .async_i(hit_orig_i),
      .rise_o (rise_a)
   );

   ccc_sync_edge #(.STAGES(SYNC_STAGES)) i_sync_b (
      .clk    (clk),
      .rst    (rst),
      .async_i(hit_dly_i),
      .rise_o (rise_b)
   );

   ccc_pair_ctrl #(.CNT_W(CNT_W), .PAIR_WIN(PAIR_WIN)) i_pair (
      .clk      (clk),
      .rst      (rst),
      .rise_a_i (rise_a),
      .rise_b_i (rise_b),
      .cnt_i    (count_o),
      .coarse_o (coarse_o),
      .valid_o  (valid_o),
      .err_o    (err_o),
      .overrun_o(overrun_o)
   );

endmodule

// File: rtl/ccc_checker.sv
module ccc_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic [CNT_W-1:0] count_o,
   input logic [CNT_W-1:0] coarse_o,
   input logic             valid_o,
   input logic             err_o,
   input logic             overrun_o
);
   timeunit 1ns;
   timeprecision 100ps;

   // R1: counter steps by one per cycle outside reset, with wrap
   a_r1_count_step: assert property (@(posedge clk)
      !rst |=> count_o == CNT_W'($past(count_o) + 1'b1));

   // R2: reset clears counter and all flags
   a_r2_reset_clear: assert property (@(posedge clk)
      rst |=> (count_o == '0 && !valid_o && !err_o && !overrun_o));

   // R8: error is only reported with a strobe
   a_r8_err_with_valid: assert property (@(posedge clk) disable iff (rst)
      err_o |-> valid_o);

   // R8: result only moves together with a strobe
   a_r8_coarse_hold: assert property (@(posedge clk) disable iff (rst)
      !$stable(coarse_o) |-> valid_o);

   // R10: overrun stays set until reset
   a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
      overrun_o |=> overrun_o);

endmodule

bind coarse_pair_corrector ccc_checker #(.CNT_W(CNT_W)) i_ccc_checker (
   .clk      (clk),
   .rst      (rst),
   .count_o  (count_o),
   .coarse_o (coarse_o),
   .valid_o  (valid_o),
   .err_o    (err_o),
   .overrun_o(overrun_o)
);

// File: tb/test_coarse_pair_corrector.sv
module test_coarse_pair_corrector;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        hit_orig_i = 1'b0;
   logic        hit_dly_i = 1'b0;
   logic [15:0] count_o, coarse_o;
   logic        valid_o, err_o, overrun_o;

   int   n_run = 0;
   int   n_fail = 0;
   int   n_val = 0;
   logic [15:0] got_c;
   logic        got_e;
   bit   finished = 1'b0;

   always #2.5 clk = ~clk;

   coarse_pair_corrector i_coarse_pair_corrector (
      .clk      (clk),
      .rst      (rst),
      .hit_orig_i(hit_orig_i),
      .hit_dly_i(hit_dly_i),
      .count_o  (count_o),
      .coarse_o (coarse_o),
      .valid_o  (valid_o),
      .err_o    (err_o),
      .overrun_o(overrun_o)
   );

   always @(negedge clk) begin
      if (valid_o) begin
         n_val++;
         got_c = coarse_o;
         got_e = err_o;
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Expected result from the two raw captures (R4..R7, R11)
   task automatic predict(input logic [15:0] ra, input logic [15:0] rb,
                          output logic [15:0] ec, output logic ee);
      logic [15:0] d;
      d  = rb - ra;
      ec = ra;
      ee = 1'b0;
      if (d == 16'd2)          ec = ra + 16'd1;
      else if (d == 16'hFFFF)  ec = ra - 16'd1;
      else if (d > 16'd1)      ee = 1'b1;
   endtask

   // Drive one event; offsets in ns after a reference rising edge (R3)
   task automatic run_pair(input bit use_a, input bit use_b,
                           input realtime ta, input realtime tb,
                           output logic [15:0] ra, output logic [15:0] rb);
      logic [15:0] c;
      @(posedge clk);
      #0.5;
      c     = count_o;
      n_val = 0;
      ra    = c + 16'(($rtoi(ta) / 5) + 2);
      rb    = c + 16'(($rtoi(tb) / 5) + 2);
      fork
         begin
            if (use_a) begin
               #(ta - 0.5) hit_orig_i = 1'b1;
               #12 hit_orig_i = 1'b0;
            end
         end
         begin
            if (use_b) begin
               #(tb - 0.5) hit_dly_i = 1'b1;
               #12 hit_dly_i = 1'b0;
            end
         end
      join
      repeat (10) @(negedge clk);
   endtask

   task automatic pair_check(input string tag, input realtime ta, input realtime tb);
      logic [15:0] ra, rb, ec;
      logic        ee;
      run_pair(1'b1, 1'b1, ta, tb, ra, rb);
      predict(ra, rb, ec, ee);
      chk({tag, " R8 strobe count"}, n_val, 1);
      chk({tag, " coarse"}, got_c, ec);
      chk({tag, " err"}, got_e, ee);
   endtask

   task automatic t_reset;
      logic [15:0] c0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 count in reset", count_o, 0);
      chk("R2 valid in reset", valid_o, 0);
      chk("R2 err in reset", err_o, 0);
      chk("R2 overrun in reset", overrun_o, 0);
      rst = 1'b0;
      @(negedge clk);
      c0 = count_o;
      @(negedge clk);
      chk("R1 count step", count_o, c0 + 16'd1);
   endtask

   task automatic t_same_cycle;   pair_check("R4 R3 diff0", 1.0, 3.5);   endtask
   task automatic t_next_cycle;   pair_check("R4 diff1", 3.0, 5.5);      endtask
   task automatic t_late_dly;     pair_check("R5 diff2", 1.0, 11.0);     endtask
   task automatic t_early_dly;    pair_check("R6 diffm1", 6.0, 1.0);    endtask
   task automatic t_bad_diff;     pair_check("R7 diffm2", 11.0, 1.0);   endtask

   task automatic t_lone_orig;
      logic [15:0] ra, rb;
      run_pair(1'b1, 1'b0, 1.0, 1.0, ra, rb);
      chk("R9 lone orig strobe", n_val, 1);
      chk("R9 lone orig coarse", got_c, ra);
      chk("R9 lone orig err", got_e, 1);
   endtask

   task automatic t_lone_dly;
      logic [15:0] ra, rb;
      run_pair(1'b0, 1'b1, 1.0, 1.0, ra, rb);
      chk("R9 lone dly strobe", n_val, 1);
      chk("R9 lone dly coarse", got_c, rb);
      chk("R9 lone dly err", got_e, 1);
   endtask

   task automatic t_wrap;
      while (count_o != 16'hFFFC) @(negedge clk);
      pair_check("R11 wrap", 1.0, 11.0);
   endtask

   task automatic t_overrun;
      logic [15:0] c;
      @(posedge clk);
      #0.5;
      c     = count_o;
      n_val = 0;
      fork
         begin
            #0.5  hit_orig_i = 1'b1;
            #5    hit_orig_i = 1'b0;
            #5    hit_orig_i = 1'b1;
            #10   hit_orig_i = 1'b0;
         end
         begin
            #10.5 hit_dly_i = 1'b1;
            #12   hit_dly_i = 1'b0;
         end
      join
      repeat (10) @(negedge clk);
      chk("R10 overrun strobe count", n_val, 1);
      chk("R10 overrun coarse", got_c, c + 16'd3);
      chk("R10 overrun err", got_e, 0);
      chk("R10 overrun flag", overrun_o, 1);
      pair_check("R10 after overrun", 1.0, 3.5);
      chk("R10 overrun still set", overrun_o, 1);
   endtask

   task automatic t_reset_again;
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R2 overrun cleared", overrun_o, 0);
      chk("R1 count cleared", count_o, 0);
      rst = 1'b0;
      pair_check("R4 after reset", 3.0, 5.5);
   endtask

   initial begin
      t_reset();
      t_same_cycle();
      t_next_cycle();
      t_late_dly();
      t_early_dly();
      t_bad_diff();
      t_lone_orig();
      t_lone_dly();
      t_wrap();
      t_overrun();
      t_reset_again();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule